// File: doc/BRIEF.md
# Monitor-and-Wait Wakeup Controller

This block puts a core into a low-power wait state that watches one address and decides when the wait ends. Software first sends an arm command, which records the address to watch. A wait command then stalls the core. The stall lasts until one of three events: a store to the same 64-byte line, a pending interrupt that is allowed to break the wait, or the end of an optional countdown measured in clock cycles.

When the wait ends, the block gives a one-cycle wake pulse together with a 2-bit reason code. While the core is waiting, the block also shows the requested C-state and substate, taken from the hint operand. If a command carries reserved control bits, it is refused and the block raises a one-cycle fault pulse instead.

A store can reach the watched line after the arm command but before the wait command. It is remembered, so the next wait finishes at once. A wait with no live arm behind it also finishes at once.

Top module: `mwake_ctrl`

## Requirements
- R1: An arm command with an all-zero control operand records `arm_addr` and makes the controller armed. An arm command with any nonzero control bit gives `fault` high for one cycle, the cycle after the command, and leaves the armed state and the recorded address unchanged.
- R2: A plain wait (`wait_timed`=0) with any of control bits 31:1 set is refused. A timed wait (`wait_timed`=1) with any of control bits 31:2 set is refused. A refused wait gives a one-cycle `fault` in the next cycle, does not enter the wait state, and does not change the armed state.
- R3: A legal wait issued while armed, with no pending line hit, sets `waiting` in the cycle after the command. `waiting` stays high until the cycle in which `wake` rises.
- R4: While waiting, a `st_vld` whose address matches the recorded address in bits above bit 5 ends the wait with reason 00. Address bits 5:0 take no part in the match.
- R5: While waiting, `irq_pend` ends the wait with reason 01 when `irq_en` is high or when control bit 0 of the wait was set. If neither is true, `irq_pend` has no effect.
- R6: On a timed wait with control bit 1 set, and with no other event, `waiting` stays high for exactly `wait_limit`+1 cycles and then `wake` rises with reason 10. If bit 1 is clear, or on a plain wait, no timeout occurs.
- R7: When more than one wake condition holds in the same cycle, the reason reported is store (00) first, then interrupt (01), then timeout (10).
- R8: A matching store in a cycle with no command, while armed and not waiting, is remembered. The next legal wait then gives `wake` with reason 00 in the following cycle, and `waiting` never rises.
- R9: A legal wait with no live arm gives `wake` with reason 00 in the following cycle, and `waiting` never rises. Every wake clears the armed state, so each arm serves at most one wait.
- R10: `wake` is high for single cycles only. `wake_why` reads 00 whenever `wake` is low, and the code 11 is never produced.
- R11: While `waiting` is high, `cst_hint` equals hint bits 7:4 and `sub_hint` equals hint bits 3:0 of the wait that started it. Both read zero while `waiting` is low.
- R12: Arm and wait commands issued while waiting are ignored. If an arm and a wait arrive in the same cycle, the arm is processed and the wait is dropped.
- R13: After a synchronous reset, `waiting`, `wake`, `fault`, `wake_why` and both hint outputs are zero, and the controller is unarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_vld | input | 1 | Arm command strobe |
| arm_addr | input | ADDR_W | Address to monitor |
| arm_ctl | input | 32 | Arm control operand, must be zero |
| wait_vld | input | 1 | Wait command strobe |
| wait_timed | input | 1 | Selects the timed wait variant |
| wait_ctl | input | 32 | Wait control operand (bit 0 interrupt break, bit 1 timeout enable) |
| wait_hint | input | 8 | Hint operand: C-state in 7:4, substate in 3:0 |
| wait_limit | input | TMR_W | Maximum wait length in clock cycles |
| st_vld | input | 1 | Snooped store valid |
| st_addr | input | ADDR_W | Snooped store address |
| irq_pend | input | 1 | Interrupt pending |
| irq_en | input | 1 | Interrupt-enable flag of the core |
| waiting | output | 1 | Core is held in the wait state |
| wake | output | 1 | One-cycle wake pulse |
| wake_why | output | 2 | Wake reason: 00 store, 01 interrupt, 10 timeout |
| fault | output | 1 | One-cycle pulse for an illegal operand |
| cst_hint | output | 4 | Target C-state while waiting |
| sub_hint | output | 4 | Target substate while waiting |

## Verification
Directed cases pair stores just inside and just outside the watched line, so the bench can tell a line-granular match from a full-address match or from a match on the wrong bits. Interrupts are sent with the enable flag and the break bit in all combinations, which shows whether each of the two paths can end the wait. Countdown limits of zero and three, together with events that coincide in one cycle, expose off-by-one timing and any error in priority. A long random mix of arms, waits, stores to a handful of nearby lines and illegal control words then covers hits before the wait, back-to-back commands and refused operands.

// File: rtl/mwake_pkg.sv
package mwake_pkg;

    localparam int unsigned CTL_W       = 32;
    localparam int unsigned HINT_W      = 8;
    localparam int unsigned CTL_BRK_BIT = 0;
    localparam int unsigned CTL_TMO_BIT = 1;

    typedef enum logic [1:0] {
        WHY_STORE = 2'b00,
        WHY_IRQ   = 2'b01,
        WHY_TMO   = 2'b10,
        WHY_RSVD  = 2'b11
    } why_e;

    typedef struct packed {
        logic       brk;
        logic       tmo_en;
        logic [3:0] cst;
        logic [3:0] sub;
    } wctx_t;

    typedef struct packed {
        logic st;
        logic irq;
        logic tmo;
    } wcond_t;

    function automatic logic arm_ctl_bad(input logic [CTL_W-1:0] c);
        return c != '0;
    endfunction

    function automatic logic wait_ctl_bad(input logic [CTL_W-1:0] c, input logic timed);
        return timed ? ((c >> 2) != '0) : ((c >> 1) != '0);
    endfunction

    function automatic why_e pick_why(input wcond_t w);
        if (w.st)       return WHY_STORE;
        else if (w.irq) return WHY_IRQ;
        else            return WHY_TMO;
    endfunction

    function automatic wctx_t mk_ctx(input logic [CTL_W-1:0] c, input logic timed,
                                     input logic [HINT_W-1:0] h);
        wctx_t x;
        x.brk    = c[CTL_BRK_BIT];
        x.tmo_en = timed & c[CTL_TMO_BIT];
        x.cst    = h[7:4];
        x.sub    = h[3:0];
        return x;
    endfunction

endpackage

// File: rtl/mwake_opchk.sv
module mwake_opchk
    import mwake_pkg::*;
(
    input  logic [CTL_W-1:0] arm_ctl,
    input  logic [CTL_W-1:0] wait_ctl,
    input  logic             wait_timed,
    output logic             arm_bad,
    output logic             wait_bad
);
    always_comb begin
        arm_bad  = arm_ctl_bad(arm_ctl);
        wait_bad = wait_ctl_bad(wait_ctl, wait_timed);
    end
endmodule

// File: rtl/mwake_match.sv
module mwake_match #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned LINE_BITS = 6
) (
    input  logic [ADDR_W-1:0] ref_addr,
    input  logic [ADDR_W-1:0] obs_addr,
    output logic              hit
);
    logic [ADDR_W-1:0] diff;
    assign diff = ref_addr ^ obs_addr;

    generate
        if (LINE_BITS == 0) begin : g_exact
            assign hit = (diff == '0);
        end else begin : g_line
            assign hit = ((diff >> LINE_BITS) == '0);
        end
    endgenerate
endmodule

// File: rtl/mwake_timer.sv
module mwake_timer #(
    parameter int unsigned TMR_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);
    logic [TMR_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                      cnt <= '0;
        else if (load)                cnt <= load_val;
        else if (run && cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    AST_TMR_DEC: assert property (@(posedge clk) disable iff (rst)
        (run && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R6
endmodule

// File: rtl/mwake_ctrl.sv
module mwake_ctrl
    import mwake_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned TMR_W     = 32,
    parameter int unsigned LINE_BITS = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_vld,
    input  logic [ADDR_W-1:0] arm_addr,
    input  logic [CTL_W-1:0]  arm_ctl,
    input  logic              wait_vld,
    input  logic              wait_timed,
    input  logic [CTL_W-1:0]  wait_ctl,
    input  logic [HINT_W-1:0] wait_hint,
    input  logic [TMR_W-1:0]  wait_limit,
    input  logic              st_vld,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              irq_pend,
    input  logic              irq_en,
    output logic              waiting,
    output logic              wake,
    output logic [1:0]        wake_why,
    output logic              fault,
    output logic [3:0]        cst_hint,
    output logic [3:0]        sub_hint
);
    logic              armed, hit_pend;
    logic [ADDR_W-1:0] addr_q;
    wctx_t             ctx_q;
    why_e              why_q;
    logic              arm_bad, wait_bad, line_hit, tmr_exp;
    logic              go_wait;
    wcond_t            cond;

    mwake_opchk u_chk (
        .arm_ctl   (arm_ctl),
        .wait_ctl  (wait_ctl),
        .wait_timed(wait_timed),
        .arm_bad   (arm_bad),
        .wait_bad  (wait_bad)
    );

    mwake_match #(.ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS)) u_match (
        .ref_addr(addr_q),
        .obs_addr(st_addr),
        .hit     (line_hit)
    );

    // a wait that really stalls: idle, no arm this cycle, legal, armed, no pending hit
    assign go_wait = !waiting && !arm_vld && wait_vld && !wait_bad && armed && !hit_pend;

    mwake_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (go_wait),
        .load_val(wait_limit),
        .run     (waiting && ctx_q.tmo_en),
        .expired (tmr_exp)
    );

    always_comb begin
        cond.st  = st_vld && line_hit;
        cond.irq = irq_pend && (irq_en || ctx_q.brk);
        cond.tmo = ctx_q.tmo_en && tmr_exp;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            waiting  <= 1'b0;
            armed    <= 1'b0;
            hit_pend <= 1'b0;
            addr_q   <= '0;
            ctx_q    <= '0;
            wake     <= 1'b0;
            why_q    <= WHY_STORE;
            fault    <= 1'b0;
        end else begin
            wake  <= 1'b0;
            why_q <= WHY_STORE;
            fault <= 1'b0;
            if (waiting) begin
                if (cond.st || cond.irq || cond.tmo) begin
                    waiting  <= 1'b0;
                    wake     <= 1'b1;
                    why_q    <= pick_why(cond);
                    armed    <= 1'b0;
                    hit_pend <= 1'b0;
                end
            end else if (arm_vld) begin
                if (arm_bad) begin
                    fault <= 1'b1;
                end else begin
                    armed    <= 1'b1;
                    addr_q   <= arm_addr;
                    hit_pend <= 1'b0;
                end
            end else if (wait_vld) begin
                if (wait_bad) begin
                    fault <= 1'b1;
                end else if (!armed || hit_pend) begin
                    wake     <= 1'b1;
                    armed    <= 1'b0;
                    hit_pend <= 1'b0;
                end else begin
                    waiting <= 1'b1;
                    ctx_q   <= mk_ctx(wait_ctl, wait_timed, wait_hint);
                end
            end else if (armed && st_vld && line_hit) begin
                hit_pend <= 1'b1;
            end
        end
    end

    assign wake_why = why_q;
    assign cst_hint = waiting ? ctx_q.cst : 4'd0;
    assign sub_hint = waiting ? ctx_q.sub : 4'd0;

    AST_WAKE_NOT_WAITING: assert property (@(posedge clk) disable iff (rst)
        wake |-> !waiting); // R10
    AST_WAIT_ENDS_BY_WAKE: assert property (@(posedge clk) disable iff (rst)
        $fell(waiting) |-> wake); // R3
    AST_NO_RSVD_CODE: assert property (@(posedge clk) disable iff (rst)
        wake |-> (wake_why != 2'b11)); // R10
    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (rst)
        fault |-> (!waiting && !wake)); // R2
    AST_HINT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (waiting && $past(waiting)) |-> ($stable(cst_hint) && $stable(sub_hint))); // R11
    AST_STORE_FIRST: assert property (@(posedge clk) disable iff (rst)
        (waiting && st_vld && line_hit) |=> (wake && wake_why == 2'b00)); // R7
endmodule

// File: tb/sim_mwake_ctrl.sv
`timescale 1ns/1ps
module sim_mwake_ctrl;
    localparam int AW = 32;
    localparam int TW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          arm_vld, wait_vld, wait_timed, st_vld, irq_pend, irq_en;
    logic [AW-1:0] arm_addr, st_addr;
    logic [31:0]   arm_ctl, wait_ctl;
    logic [7:0]    wait_hint;
    logic [TW-1:0] wait_limit;
    logic          waiting, wake, fault;
    logic [1:0]    wake_why;
    logic [3:0]    cst_hint, sub_hint;

    always #4 clk = ~clk;

    mwake_ctrl u0 (
        .clk(clk), .rst(rst), .arm_vld(arm_vld), .arm_addr(arm_addr), .arm_ctl(arm_ctl),
        .wait_vld(wait_vld), .wait_timed(wait_timed), .wait_ctl(wait_ctl),
        .wait_hint(wait_hint), .wait_limit(wait_limit), .st_vld(st_vld), .st_addr(st_addr),
        .irq_pend(irq_pend), .irq_en(irq_en), .waiting(waiting), .wake(wake),
        .wake_why(wake_why), .fault(fault), .cst_hint(cst_hint), .sub_hint(sub_hint)
    );

    int n_vec = 0;
    int n_bad = 0;

    // reference model state
    logic          m_armed, m_hit, m_wait, m_brk, m_tmo;
    logic [AW-1:0] m_addr;
    logic [TW-1:0] m_cnt;
    logic [3:0]    m_cst, m_sub;
    logic          e_wake, e_fault;
    logic [1:0]    e_why;

    function automatic logic same_line(input logic [AW-1:0] a, input logic [AW-1:0] b);
        return a[AW-1:6] == b[AW-1:6];
    endfunction

    function automatic logic bad_wait(input logic [31:0] c, input logic t);
        return t ? (c[31:2] != 0) : (c[31:1] != 0);
    endfunction

    task automatic model_step();
        logic st, irq, tmo;
        e_wake = 0; e_fault = 0; e_why = 2'b00;
        if (rst) begin
            m_armed = 0; m_hit = 0; m_wait = 0; m_brk = 0; m_tmo = 0;
            m_addr = '0; m_cnt = '0; m_cst = 0; m_sub = 0;
        end else if (m_wait) begin
            st  = st_vld && same_line(st_addr, m_addr);
            irq = irq_pend && (irq_en || m_brk);
            tmo = m_tmo && (m_cnt == 0);
            if (st || irq || tmo) begin
                e_wake = 1; e_why = st ? 2'b00 : (irq ? 2'b01 : 2'b10);
                m_wait = 0; m_armed = 0; m_hit = 0;
            end else if (m_tmo) m_cnt = m_cnt - 1;
        end else if (arm_vld) begin
            if (arm_ctl != 0) e_fault = 1;
            else begin m_armed = 1; m_addr = arm_addr; m_hit = 0; end
        end else if (wait_vld) begin
            if (bad_wait(wait_ctl, wait_timed)) e_fault = 1;
            else if (!m_armed || m_hit) begin e_wake = 1; m_armed = 0; m_hit = 0; end
            else begin
                m_wait = 1; m_brk = wait_ctl[0]; m_tmo = wait_timed && wait_ctl[1];
                m_cnt = wait_limit; m_cst = wait_hint[7:4]; m_sub = wait_hint[3:0];
            end
        end else if (m_armed && st_vld && same_line(st_addr, m_addr)) m_hit = 1;
    endtask

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(tag, "waiting", 32'(waiting), 32'(m_wait));
        chk(tag, "wake", 32'(wake), 32'(e_wake));
        chk(tag, "wake_why", 32'(wake_why), 32'(e_why));
        chk(tag, "fault", 32'(fault), 32'(e_fault));
        chk(tag, "cst_hint", 32'(cst_hint), 32'(m_wait ? m_cst : 4'd0));
        chk(tag, "sub_hint", 32'(sub_hint), 32'(m_wait ? m_sub : 4'd0));
        arm_vld = 0; wait_vld = 0; st_vld = 0; irq_pend = 0;
    endtask

    task automatic idle_in();
        arm_vld = 0; wait_vld = 0; wait_timed = 0; st_vld = 0; irq_pend = 0; irq_en = 0;
        arm_addr = '0; st_addr = '0; arm_ctl = 0; wait_ctl = 0; wait_hint = 0; wait_limit = 0;
    endtask

    task automatic do_arm(input logic [AW-1:0] a, input logic [31:0] c, input string tag);
        arm_vld = 1; arm_addr = a; arm_ctl = c; step(tag);
    endtask

    task automatic do_wait(input logic t, input logic [31:0] c, input logic [7:0] h,
                           input logic [TW-1:0] lim, input string tag);
        wait_vld = 1; wait_timed = t; wait_ctl = c; wait_hint = h; wait_limit = lim; step(tag);
    endtask

    task automatic do_store(input logic [AW-1:0] a, input string tag);
        st_vld = 1; st_addr = a; step(tag);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        int unsigned seed;
        int unsigned r;
        logic [AW-1:0] base;
        seed = 32'd20240611;
        r = $urandom(seed);
        idle_in();
        rst = 1;
        step("R13 reset");
        step("R13 reset");
        rst = 0;
        step("R13 after reset");

        // R1: illegal arm
        do_arm(32'h1000, 32'h1, "R1 arm bad ctl");
        do_wait(0, 0, 8'h21, 0, "R9 wait unarmed immediate");
        step("R10 wake single");
        // R1 legal arm then R3 / R11 wait
        do_arm(32'h2000, 0, "R1 arm legal");
        do_arm(32'h5000, 32'h80000000, "R1 bad arm keeps address");
        do_wait(0, 32'h2, 8'h00, 0, "R2 plain wait bit1 fault");
        do_wait(1, 32'h4, 8'h00, 0, "R2 timed wait bit2 fault");
        do_wait(0, 0, 8'h53, 0, "R3 R11 enter wait");
        do_store(32'h5000, "R1 R4 store old line ignored");
        do_store(32'h2040, "R4 next line ignored");
        irq_pend = 1; irq_en = 0; step("R5 irq masked ignored");
        do_arm(32'h3000, 0, "R12 arm while waiting ignored");
        do_store(32'h203F, "R4 store same line wakes");
        step("R10 after wake");
        do_wait(0, 0, 8'h11, 0, "R9 arm consumed immediate");
        step("R9 gap");

        // R5: interrupt paths
        do_arm(32'h4000, 0, "R5 arm");
        do_wait(0, 0, 8'hA7, 0, "R5 wait");
        irq_pend = 1; irq_en = 1; step("R5 irq enabled wakes");
        irq_en = 0;
        do_arm(32'h4000, 0, "R5 arm");
        do_wait(0, 32'h1, 8'h34, 0, "R5 wait break bit");
        irq_pend = 1; step("R5 irq via break bit");

        // R6: timeout of 3 -> 4 waiting cycles
        do_arm(32'h6000, 0, "R6 arm");
        do_wait(1, 32'h2, 8'hF2, 3, "R6 timed wait");
        for (int i = 0; i < 4; i++) step("R6 countdown");
        step("R6 after timeout");
        do_arm(32'h6000, 0, "R6 arm");
        do_wait(1, 32'h2, 8'h12, 0, "R6 limit zero");
        step("R6 limit zero fires");
        do_arm(32'h6000, 0, "R6 arm");
        do_wait(1, 32'h0, 8'h12, 0, "R6 timer disabled");
        for (int i = 0; i < 5; i++) step("R6 no timeout");
        irq_pend = 1; irq_en = 1; step("R6 exit by irq");

        // R7: coincident events
        do_arm(32'h7000, 0, "R7 arm");
        do_wait(1, 32'h3, 8'h00, 1, "R7 wait");
        step("R7 tick");
        st_vld = 1; st_addr = 32'h7008; irq_pend = 1; step("R7 store beats irq and timeout");
        do_arm(32'h7000, 0, "R7 arm");
        do_wait(1, 32'h3, 8'h00, 0, "R7 wait");
        irq_pend = 1; step("R7 irq beats timeout");

        // R8: store between arm and wait
        do_arm(32'h8000, 0, "R8 arm");
        do_store(32'h8010, "R8 early store");
        step("R8 idle");
        do_wait(0, 0, 8'h44, 0, "R8 immediate wake");
        // R12: arm and wait same cycle
        arm_vld = 1; arm_addr = 32'h9000; arm_ctl = 0;
        wait_vld = 1; wait_ctl = 0; step("R12 arm wins over wait");
        do_wait(0, 0, 8'h66, 0, "R12 later wait stalls");
        do_store(32'h9000, "R12 exit");

        // random phase
        irq_en = 0;
        for (int i = 0; i < 4000; i++) begin
            r = $urandom % 100;
            base = 32'h0001_0000 + (($urandom % 4) << 6);
            if (r < 10) begin
                arm_vld = 1; arm_addr = base + ($urandom % 64);
                arm_ctl = (($urandom % 8) == 0) ? (32'h1 << ($urandom % 32)) : 0;
            end else if (r < 22) begin
                wait_vld = 1; wait_timed = $urandom % 2; wait_hint = 8'($urandom);
                wait_ctl = 32'($urandom % 4);
                if (($urandom % 8) == 0) wait_ctl = wait_ctl | (32'h1 << ($urandom % 32));
                wait_limit = TW'($urandom % 8);
            end
            if (($urandom % 3) == 0) begin st_vld = 1; st_addr = base + ($urandom % 64); end
            irq_pend = (($urandom % 10) == 0);
            irq_en = (($urandom % 4) == 0);
            step("R4 R5 R6 R7 R8 random mix");
        end
        summary();
    end
endmodule